// File: doc/BRIEF.md
# Compressed-Table Sine Synthesizer

This block is a numerically controlled oscillator. A 32-bit phase register adds a tuning word on every accepted step, wrapping modulo 2^32, and the upper 12 bits of that phase drive a converter that produces a signed 10-bit sine sample. The output frequency is `tune_word / 2^32` times the sample rate.

The converter holds no full sine table. The two top phase bits choose a quadrant. The second bit mirrors the 10-bit in-quadrant phase, and the top bit negates the result. The block never stores the sine directly. It stores what is left once a straight phase ramp is taken away from it. That residue is built from three sources: four straight-line pieces, each with an offset and a slope; a 64-entry coarse correction; and a 128-entry fine error table. The sum, plus the phase ramp, is rounded to the output. All table contents are computed when the design is elaborated.

Samples leave through a valid/ready stream. `out_valid` and `out_data` hold unchanged while `out_ready` is low. During such a stall the whole pipeline freezes, including the phase register, and `tune_word` is ignored. When the port is empty the pipeline always advances. A new sample therefore arrives on every cycle in which the consumer accepts one.

Top module: `qsine_dds`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0; the phase register restarts from 0.
- R2: After reset is released, `out_valid` rises at the third rising clock edge and then stays high until the next reset.
- R3: Each accepted step adds the `tune_word` present at that edge to the phase, modulo 2^32. The sample shown after step n carries the phase held before step n-2. The first valid sample therefore carries phase 0.
- R4: With P the top 12 phase bits, every valid sample is within 2 LSB of 511·sin(2π(P+0.5)/4096).
- R5: Phase codes P and P+2048 give samples that are exact two's-complement negatives of each other.
- R6: For P below 1024, phase codes P and 2047-P give identical samples.
- R7: `out_data` is a two's-complement value that never equals -512.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle shows the same `out_data` with `out_valid` still 1. The phase register does not move, and a `tune_word` change made during the stall has no effect on later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tune_word | input | 32 | Phase increment per accepted sample |
| out_ready | input | 1 | Consumer accepts the current sample |
| out_valid | output | 1 | `out_data` holds a sample |
| out_data | output | 10 | Signed sine sample |

## Verification
The bench builds the block with its default parameters: a 32-bit phase, 12 converter phase bits, 10 output bits, 4 line pieces, 64 coarse entries and 8×16 fine entries. A tuning word of 2^20 advances one phase code per sample. This visits all 4096 codes, so every line piece and every coarse and fine entry is read. The same sweep makes the exact quadrant negation and mirroring checks possible across the whole circle. A word of 2^31 alternates between opposite quadrants. Random words with a randomly stalling consumer, a wrapping negative step and a mid-stream reset drive the freeze and restart behaviour.

// File: rtl/qsdds_pkg.sv
package qsdds_pkg;

  // pi in Q30
  localparam longint PI_Q30 = 64'sd3373259426;

  // Sine at the centre of folded phase code x, in quarter-LSB units
  function automatic int qs_sine_q2(int x, int fold_w, int amp_w);
    longint th;
    longint term;
    longint sum;
    longint pk;
    th   = (longint'(2 * x + 1) * PI_Q30) >>> (fold_w + 2);
    sum  = th;
    term = th;
    for (int k = 1; k <= 7; k++) begin
      term = -((((term * th) >>> 30) * th) >>> 30) / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    pk = longint'(4 * ((1 << (amp_w - 1)) - 1));
    return int'(((sum * pk) + (64'sd1 <<< 29)) >>> 30);
  endfunction

  // Straight phase ramp in quarter-LSB units
  function automatic int qs_ramp_q2(int x, int fold_w, int amp_w);
    return (x << (amp_w + 1)) >> fold_w;
  endfunction

  // Sine minus ramp
  function automatic int qs_resid(int x, int fold_w, int amp_w);
    return qs_sine_q2(x, fold_w, amp_w) - qs_ramp_q2(x, fold_w, amp_w);
  endfunction

  function automatic int qs_seg_off(int s, int fold_w, int amp_w, int seg_b);
    return qs_resid(s << (fold_w - seg_b), fold_w, amp_w);
  endfunction

  function automatic int qs_seg_slope(int s, int fold_w, int amp_w, int seg_b);
    int x0;
    int x1;
    x0 = s << (fold_w - seg_b);
    x1 = x0 + (1 << (fold_w - seg_b)) - 1;
    return qs_resid(x1, fold_w, amp_w) - qs_resid(x0, fold_w, amp_w);
  endfunction

  // Line-piece estimate, same arithmetic as the hardware (floor shift)
  function automatic int qs_line(int x, int fold_w, int amp_w, int seg_b);
    int lw;
    int s;
    int xl;
    lw = fold_w - seg_b;
    s  = x >> lw;
    xl = x & ((1 << lw) - 1);
    return qs_seg_off(s, fold_w, amp_w, seg_b) +
           ((qs_seg_slope(s, fold_w, amp_w, seg_b) * xl) >>> lw);
  endfunction

  // Coarse correction: line error at the centre of block j
  function automatic int qs_coarse(int j, int fold_w, int amp_w, int seg_b, int crs_b);
    int bw;
    int ctr;
    bw  = fold_w - crs_b;
    ctr = (j << bw) + (1 << (bw - 1));
    return qs_resid(ctr, fold_w, amp_w) - qs_line(ctr, fold_w, amp_w, seg_b);
  endfunction

  // Fine correction: mean leftover error at in-block offset k over one sub-range
  function automatic int qs_err(int idx, int fold_w, int amp_w, int seg_b, int crs_b,
                                int sub_b);
    int bw;
    int sub;
    int k;
    int nsh;
    int sum;
    int j;
    int x;
    bw  = fold_w - crs_b;
    sub = idx >> bw;
    k   = idx & ((1 << bw) - 1);
    nsh = crs_b - sub_b;
    sum = 0;
    for (int b = 0; b < (1 << nsh); b++) begin
      j   = (sub << nsh) + b;
      x   = (j << bw) + k;
      sum = sum + qs_resid(x, fold_w, amp_w) - qs_line(x, fold_w, amp_w, seg_b)
                - qs_coarse(j, fold_w, amp_w, seg_b, crs_b);
    end
    return (sum + ((1 << nsh) >> 1)) >>> nsh;
  endfunction

endpackage

// File: rtl/qsdds_accum.sv
module qsdds_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] tune,
  output logic [ACC_W-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  phase <= '0;
    else if (en) phase <= phase + tune;
  end
endmodule

// File: rtl/qsdds_fold.sv
module qsdds_fold #(
  parameter int PH_W = 12,
  localparam int FOLD_W = PH_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PH_W-1:0]   ph,
  output logic [FOLD_W-1:0] x,
  output logic              neg
);
  logic [FOLD_W-1:0] x_d;

  // second phase bit mirrors inside the quadrant
  assign x_d = ph[PH_W-2] ? ~ph[FOLD_W-1:0] : ph[FOLD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x   <= '0;
      neg <= 1'b0;
    end else if (en) begin
      x   <= x_d;
      neg <= ph[PH_W-1];
    end
  end
endmodule

// File: rtl/qsdds_resid.sv
module qsdds_resid #(
  parameter int FOLD_W   = 10,
  parameter int AMP_W    = 10,
  parameter int SEG_BITS = 2,
  parameter int CRS_BITS = 6,
  parameter int SUB_BITS = 3,
  localparam int RES_W   = AMP_W + 3,
  localparam int SUM_W   = AMP_W + 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [FOLD_W-1:0]       x_in,
  input  logic                    neg_in,
  output logic [FOLD_W-1:0]       x_out,
  output logic                    neg_out,
  output logic signed [SUM_W-1:0] resid
);
  localparam int LOW_W = FOLD_W - SEG_BITS;
  localparam int BLK_W = FOLD_W - CRS_BITS;
  localparam int SEGS  = 1 << SEG_BITS;
  localparam int CRS_N = 1 << CRS_BITS;
  localparam int ERR_N = 1 << (SUB_BITS + BLK_W);
  localparam int PW    = RES_W + LOW_W + 1;

  logic signed [RES_W-1:0] off_rom   [SEGS];
  logic signed [RES_W-1:0] slope_rom [SEGS];
  logic signed [RES_W-1:0] crs_rom   [CRS_N];
  logic signed [RES_W-1:0] err_rom   [ERR_N];

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    localparam int OFFV = qsdds_pkg::qs_seg_off(i, FOLD_W, AMP_W, SEG_BITS);
    localparam int SLPV = qsdds_pkg::qs_seg_slope(i, FOLD_W, AMP_W, SEG_BITS);
    assign off_rom[i]   = RES_W'(OFFV);
    assign slope_rom[i] = RES_W'(SLPV);
  end

  for (genvar j = 0; j < CRS_N; j++) begin : g_crs
    localparam int CV = qsdds_pkg::qs_coarse(j, FOLD_W, AMP_W, SEG_BITS, CRS_BITS);
    assign crs_rom[j] = RES_W'(CV);
  end

  for (genvar e = 0; e < ERR_N; e++) begin : g_err
    localparam int EV = qsdds_pkg::qs_err(e, FOLD_W, AMP_W, SEG_BITS, CRS_BITS, SUB_BITS);
    assign err_rom[e] = RES_W'(EV);
  end

  logic [SEG_BITS-1:0]          seg;
  logic [LOW_W-1:0]             xl;
  logic [CRS_BITS-1:0]          cidx;
  logic [SUB_BITS+BLK_W-1:0]    eidx;
  logic signed [PW-1:0]         slope_x;
  logic signed [PW-1:0]         xl_x;
  logic signed [PW-1:0]         prod;
  logic signed [PW-1:0]         prod_sh;
  logic signed [SUM_W-1:0]      line_v;
  logic signed [SUM_W-1:0]      sum_v;

  assign seg  = x_in[FOLD_W-1 -: SEG_BITS];
  assign xl   = x_in[LOW_W-1:0];
  assign cidx = x_in[FOLD_W-1 -: CRS_BITS];
  assign eidx = {x_in[FOLD_W-1 -: SUB_BITS], x_in[BLK_W-1:0]};

  always_comb begin
    slope_x = PW'(slope_rom[seg]);
    xl_x    = PW'({1'b0, xl});
    prod    = slope_x * xl_x;
    prod_sh = prod >>> LOW_W;
    line_v  = SUM_W'(off_rom[seg]) + SUM_W'(prod_sh);
    sum_v   = line_v + SUM_W'(crs_rom[cidx]) + SUM_W'(err_rom[eidx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_out   <= '0;
      neg_out <= 1'b0;
      resid   <= '0;
    end else if (en) begin
      x_out   <= x_in;
      neg_out <= neg_in;
      resid   <= sum_v;
    end
  end
endmodule

// File: rtl/qsdds_shape.sv
module qsdds_shape #(
  parameter int FOLD_W = 10,
  parameter int AMP_W  = 10,
  localparam int SUM_W = AMP_W + 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [FOLD_W-1:0]       x,
  input  logic                    neg,
  input  logic signed [SUM_W-1:0] resid,
  output logic signed [AMP_W-1:0] sample
);
  localparam int RAMP_W = FOLD_W + AMP_W + 1;
  localparam int AMAX   = (1 << (AMP_W - 1)) - 1;

  logic [RAMP_W-1:0]        ramp_w;
  logic signed [SUM_W-1:0]  ramp_q2;
  logic signed [SUM_W-1:0]  total;
  logic signed [SUM_W-1:0]  rnd;
  logic signed [AMP_W-1:0]  amp;
  logic signed [AMP_W-1:0]  signed_amp;

  always_comb begin
    ramp_w  = {x, {(AMP_W + 1){1'b0}}} >> FOLD_W;
    ramp_q2 = $signed(SUM_W'(ramp_w));
    total   = ramp_q2 + resid;
    rnd     = (total + SUM_W'(2)) >>> 2;
    if (rnd > SUM_W'(AMAX))   amp = AMP_W'(AMAX);
    else if (rnd < 0)         amp = '0;
    else                      amp = AMP_W'(rnd);
    signed_amp = neg ? -amp : amp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sample <= '0;
    else if (en) sample <= signed_amp;
  end
endmodule

// File: rtl/qsine_dds.sv
module qsine_dds #(
  parameter int ACC_W    = 32,
  parameter int PH_W     = 12,
  parameter int AMP_W    = 10,
  parameter int SEG_BITS = 2,
  parameter int CRS_BITS = 6,
  parameter int SUB_BITS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ACC_W-1:0]        tune_word,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic signed [AMP_W-1:0] out_data
);
  localparam int FOLD_W = PH_W - 2;
  localparam int SUM_W  = AMP_W + 4;
  localparam int STAGES = 3;

  logic [ACC_W-1:0]        phase_acc;
  logic [STAGES-1:0]       vld;
  logic                    adv;
  logic [FOLD_W-1:0]       s1_x;
  logic                    s1_neg;
  logic [FOLD_W-1:0]       s2_x;
  logic                    s2_neg;
  logic signed [SUM_W-1:0] s2_resid;

  // whole pipeline moves together; it only waits on a full, unaccepted port
  assign adv       = out_ready | ~vld[STAGES-1];
  assign out_valid = vld[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld <= '0;
    else if (adv) vld <= {vld[STAGES-2:0], 1'b1};
  end

  qsdds_accum #(.ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(adv), .tune(tune_word), .phase(phase_acc)
  );

  qsdds_fold #(.PH_W(PH_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .ph(phase_acc[ACC_W-1 -: PH_W]), .x(s1_x), .neg(s1_neg)
  );

  qsdds_resid #(
    .FOLD_W(FOLD_W), .AMP_W(AMP_W), .SEG_BITS(SEG_BITS),
    .CRS_BITS(CRS_BITS), .SUB_BITS(SUB_BITS)
  ) u_resid (
    .clk(clk), .rst_n(rst_n), .en(adv), .x_in(s1_x), .neg_in(s1_neg),
    .x_out(s2_x), .neg_out(s2_neg), .resid(s2_resid)
  );

  qsdds_shape #(.FOLD_W(FOLD_W), .AMP_W(AMP_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .en(adv), .x(s2_x), .neg(s2_neg),
    .resid(s2_resid), .sample(out_data)
  );
endmodule

// File: rtl/qsine_dds_chk.sv
module qsine_dds_chk #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [AMP_W-1:0] out_data,
  input logic [ACC_W-1:0]        phase_acc
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(phase_acc)); // R8

  AST_VALID_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid); // R2

  AST_NO_FULL_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data != {1'b1, {(AMP_W-1){1'b0}}}); // R7
endmodule

bind qsine_dds qsine_dds_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .phase_acc(phase_acc)
);

// File: tb/qsine_dds_tb.sv
module qsine_dds_tb;
  localparam real PI = 3.14159265358979323846;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [31:0]       tune;
  logic              rdy;
  logic              ov;
  logic signed [9:0] od;

  always #4 clk = ~clk;

  qsine_dds u_dut (
    .clk(clk), .rst_n(rst_n), .tune_word(tune), .out_ready(rdy),
    .out_valid(ov), .out_data(od)
  );

  int n_chk = 0;
  int n_err = 0;

  // behavioural model
  longint unsigned   acc_m = 0;
  int                pipe_q[$];
  bit                last_stall = 0;
  logic signed [9:0] last_od = '0;
  bit                sweep_on = 0;
  int                sweep_val[4096];
  bit                sweep_got[4096];

  task automatic expect_eq(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_cycle();
    bit exp_v;
    exp_v = (pipe_q.size() == 3);
    if (!rst_n) begin
      expect_eq("R1 valid in reset", longint'(ov), 0);
      expect_eq("R1 data in reset", longint'(od), 0);
    end else begin
      expect_eq("R2 valid", longint'(ov), longint'(exp_v));
      if (exp_v && ov === 1'b1) begin
        int  p;
        real ideal;
        real d;
        p     = pipe_q[0];
        ideal = 511.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 4096.0);
        d     = real'(od) - ideal;
        n_chk++;
        if (d > 2.0 || d < -2.0) begin
          n_err++;
          $display("FAIL R3 R4 amplitude at phase code %0d: actual %0d expected %f",
                   p, od, ideal);
        end
        expect_eq("R7 no -512", longint'(od == -10'sd512), 0);
        if (last_stall) expect_eq("R8 held sample", longint'(od), longint'(last_od));
        if (sweep_on) begin
          sweep_val[p] = int'(od);
          sweep_got[p] = 1'b1;
        end
      end
    end
  endtask

  task automatic step_model();
    bit full;
    if (!rst_n) begin
      pipe_q.delete();
      acc_m      = 0;
      last_stall = 0;
    end else begin
      full       = (pipe_q.size() == 3);
      last_stall = full && !rdy;
      last_od    = od;
      if (!full || rdy) begin
        pipe_q.push_back(int'(acc_m >> 20));
        if (pipe_q.size() > 3) void'(pipe_q.pop_front());
        acc_m = (acc_m + longint'(tune)) & 64'hFFFF_FFFF;
      end
    end
  endtask

  task automatic tick(bit r, logic [31:0] tw, bit rd);
    @(negedge clk);
    check_cycle();
    rst_n = r;
    tune  = tw;
    rdy   = rd;
    step_model();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] tw;
    rst_n = 1'b0;
    tune  = '0;
    rdy   = 1'b0;
    // R1: reset state
    repeat (5) tick(1'b0, 32'd0, 1'b0);
    // R2 fill, R3 zero tuning word: phase 0 repeats
    repeat (20) tick(1'b1, 32'd0, 1'b1);
    // full sweep: one phase code per sample, every table entry read
    sweep_on = 1'b1;
    repeat (4096 + 8) tick(1'b1, 32'h0010_0000, 1'b1);
    sweep_on = 1'b0;
    // half-turn step: alternating opposite quadrants
    repeat (20) tick(1'b1, 32'h8000_0000, 1'b1);
    // R8: random tuning words, random back-pressure, word changes during stalls
    tw = $urandom;
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0 || $urandom_range(0, 9) == 0) tw = $urandom;
      tick(1'b1, tw, $urandom_range(0, 9) < 7);
    end
    // R1 mid-stream reset and restart
    repeat (3) tick(1'b0, $urandom, 1'b1);
    for (int i = 0; i < 500; i++) tick(1'b1, 32'h0123_4567, $urandom_range(0, 3) != 0);
    // negative step wrapping backwards
    repeat (200) tick(1'b1, 32'hFFF0_0000, 1'b1);
    // R8: long stall with the tuning word changing
    repeat (10) tick(1'b1, 32'h0400_0000, 1'b1);
    for (int i = 0; i < 15; i++) tick(1'b1, $urandom, 1'b0);
    repeat (30) tick(1'b1, 32'h0400_0000, 1'b1);
    tick(1'b1, 32'd0, 1'b1);

    // R5 / R6: exact symmetry over the sweep
    for (int i = 0; i < 2048; i++) begin
      if (sweep_got[i] && sweep_got[i + 2048])
        expect_eq("R5 half-turn negation", longint'(sweep_val[i + 2048]),
                  -longint'(sweep_val[i]));
      else
        expect_eq("R5 sweep coverage", 0, 1);
    end
    for (int i = 0; i < 1024; i++) begin
      expect_eq("R6 quadrant mirror", longint'(sweep_val[2047 - i]),
                longint'(sweep_val[i]));
    end
    finish_run();
  end
endmodule